// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This block decides which value becomes the result of a fused multiply-add `a*b+c` when at least one operand is a NaN, or when the product is infinity times zero. It receives a two-bit class code for each of the three operands. It also receives a flag saying that the multiplicands are infinity and zero, a bit giving the quiet-bit polarity, a bit choosing the first-NaN ordering and a policy number. From these it returns a two-bit pick and an invalid-operation flag.

The pick names one of the three operands or the default NaN. A later stage builds the actual NaN word from that pick and quiets a signaling operand. The selector is purely combinational, so both outputs follow the inputs within the same cycle. Five policies exist, and each has its own priority order and its own handling of infinity times zero. Any policy number above the defined ones falls back to a plain first-NaN scan.

Top module: `fma_nan_select`

## Requirements
- R1: Each class code input uses 0 for a non-NaN, 1 for a quiet NaN, 2 for a signaling NaN and 3 (reserved) treated as a non-NaN. The pick output is 0 for a, 1 for b, 2 for c and 3 for the default NaN.
- R2: Policy 0 with infzero set and c quiet picks 3 and raises invalid. In every other case it scans signaling c, signaling a, signaling b, quiet c, quiet a, and otherwise picks b.
- R3: Policy 1 with the polarity bit set picks 3 and raises invalid whenever infzero is set. Otherwise it scans signaling a, b, c, then quiet a, b, and otherwise picks c.
- R4: Policy 1 with the polarity bit clear picks c and raises invalid when infzero is set. Otherwise it scans signaling c, signaling a, signaling b, quiet c, quiet a, and otherwise picks b.
- R5: Policy 2 picks c and raises invalid when infzero is set. Otherwise it picks a if a is any NaN, then c if c is any NaN, and otherwise b.
- R6: Policy 3 always picks 3 and raises invalid from infzero alone.
- R7: Policy 4 with infzero picks c and raises invalid. Otherwise, with first-NaN mode set, it picks the first NaN among a, b, c, and c if none is a NaN.
- R8: Policy 4 without infzero and with first-NaN mode clear picks the first NaN among c, b, a, and a if none is a NaN.
- R9: Invalid is raised whenever any operand is a signaling NaN, whichever operand is picked and whatever the policy.
- R10: Policy numbers 5 and above pick the first NaN among a, b, c, and c if none is a NaN. They never pick 3, and infzero does not raise invalid for them.
- R11: Both outputs are a combinational function of the present inputs, with no state carried between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_a | input | 2 | Class code of multiplicand a |
| cls_b | input | 2 | Class code of multiplicand b |
| cls_c | input | 2 | Class code of addend c |
| infzero | input | 1 | Multiplicands are infinity and zero |
| qbit_inverted | input | 1 | Quiet-bit polarity is inverted (a set msb means signaling) |
| first_nan_mode | input | 1 | Ordering choice for policy 4 |
| policy | input | POL_W (3) | Priority policy number |
| pick | output | 2 | Chosen source: 0 a, 1 b, 2 c, 3 default NaN |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions are immediate checks inside the combinational logic. They assume that every input has a settled, known value when they are evaluated. They also assume that class code 3 only ever stands for an ordinary number. The bench meets these assumptions by driving all inputs together from time zero, one posedge after the previous vector. It then compares the outputs at the following negedge, so no check sees a half-updated set of inputs. The reserved class code is covered only by its own directed task.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

    localparam int NUM_OPS   = 3;
    localparam int NUM_RULES = 5;
    localparam int POL_W     = 3;

    localparam logic [1:0] CLS_NUM  = 2'd0;
    localparam logic [1:0] CLS_QNAN = 2'd1;
    localparam logic [1:0] CLS_SNAN = 2'd2;

    localparam logic [1:0] PICK_A   = 2'd0;
    localparam logic [1:0] PICK_B   = 2'd1;
    localparam logic [1:0] PICK_C   = 2'd2;
    localparam logic [1:0] PICK_DEF = 2'd3;

    localparam int OP_A = 0;
    localparam int OP_B = 1;
    localparam int OP_C = 2;

    typedef struct packed {
        logic [1:0] choice;
        logic       invalid;
    } nan_pick_t;

endpackage

// File: rtl/fma_nan_cls_decode.sv
module fma_nan_cls_decode
    import fma_nan_pkg::*;
(
    input  logic [1:0] cls,
    output logic       is_quiet,
    output logic       is_signal
);

    always_comb begin
        is_quiet  = (cls == CLS_QNAN);
        is_signal = (cls == CLS_SNAN);
    end

endmodule

// File: rtl/fma_nan_rule.sv
module fma_nan_rule
    import fma_nan_pkg::*;
#(
    parameter int RULE = 0
) (
    input  logic [NUM_OPS-1:0] quiet_v,
    input  logic [NUM_OPS-1:0] signal_v,
    input  logic               infzero,
    input  logic               qbit_inverted,
    input  logic               first_nan_mode,
    output nan_pick_t          res
);

    logic [NUM_OPS-1:0] nan_v;
    nan_pick_t          res_d;

    assign nan_v = quiet_v | signal_v;

    always_comb begin
        res_d.choice  = PICK_C;
        res_d.invalid = 1'b0;
        case (RULE)
            0: begin
                if (infzero && quiet_v[OP_C]) begin
                    res_d.choice  = PICK_DEF;
                    res_d.invalid = 1'b1;
                end else if (signal_v[OP_C]) res_d.choice = PICK_C;
                else if (signal_v[OP_A])     res_d.choice = PICK_A;
                else if (signal_v[OP_B])     res_d.choice = PICK_B;
                else if (quiet_v[OP_C])      res_d.choice = PICK_C;
                else if (quiet_v[OP_A])      res_d.choice = PICK_A;
                else                         res_d.choice = PICK_B;
            end
            1: begin
                if (qbit_inverted) begin
                    if (infzero) begin
                        res_d.choice  = PICK_DEF;
                        res_d.invalid = 1'b1;
                    end else if (signal_v[OP_A]) res_d.choice = PICK_A;
                    else if (signal_v[OP_B])     res_d.choice = PICK_B;
                    else if (signal_v[OP_C])     res_d.choice = PICK_C;
                    else if (quiet_v[OP_A])      res_d.choice = PICK_A;
                    else if (quiet_v[OP_B])      res_d.choice = PICK_B;
                    else                         res_d.choice = PICK_C;
                end else begin
                    if (infzero) begin
                        res_d.choice  = PICK_C;
                        res_d.invalid = 1'b1;
                    end else if (signal_v[OP_C]) res_d.choice = PICK_C;
                    else if (signal_v[OP_A])     res_d.choice = PICK_A;
                    else if (signal_v[OP_B])     res_d.choice = PICK_B;
                    else if (quiet_v[OP_C])      res_d.choice = PICK_C;
                    else if (quiet_v[OP_A])      res_d.choice = PICK_A;
                    else                         res_d.choice = PICK_B;
                end
            end
            2: begin
                if (infzero) begin
                    res_d.choice  = PICK_C;
                    res_d.invalid = 1'b1;
                end else if (nan_v[OP_A]) res_d.choice = PICK_A;
                else if (nan_v[OP_C])     res_d.choice = PICK_C;
                else                      res_d.choice = PICK_B;
            end
            3: begin
                res_d.choice  = PICK_DEF;
                res_d.invalid = infzero;
            end
            4: begin
                if (infzero) begin
                    res_d.choice  = PICK_C;
                    res_d.invalid = 1'b1;
                end else if (first_nan_mode) begin
                    if (nan_v[OP_A])      res_d.choice = PICK_A;
                    else if (nan_v[OP_B]) res_d.choice = PICK_B;
                    else                  res_d.choice = PICK_C;
                end else begin
                    if (nan_v[OP_C])      res_d.choice = PICK_C;
                    else if (nan_v[OP_B]) res_d.choice = PICK_B;
                    else                  res_d.choice = PICK_A;
                end
            end
            default: begin
                if (nan_v[OP_A])      res_d.choice = PICK_A;
                else if (nan_v[OP_B]) res_d.choice = PICK_B;
                else                  res_d.choice = PICK_C;
            end
        endcase
        // a signaling operand raises invalid under every rule
        res_d.invalid = res_d.invalid | (|signal_v);
    end

    assign res = res_d;

endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
    import fma_nan_pkg::*;
(
    input  logic [1:0]       cls_a,
    input  logic [1:0]       cls_b,
    input  logic [1:0]       cls_c,
    input  logic             infzero,
    input  logic             qbit_inverted,
    input  logic             first_nan_mode,
    input  logic [POL_W-1:0] policy,
    output logic [1:0]       pick,
    output logic             invalid
);

    localparam int RULE_SLOTS = NUM_RULES + 1;

    logic [1:0]         cls_v [NUM_OPS];
    logic [NUM_OPS-1:0] quiet_v;
    logic [NUM_OPS-1:0] signal_v;
    logic [3:0]         nan_pad;
    nan_pick_t          rule_res [RULE_SLOTS];
    nan_pick_t          sel_d;

    assign cls_v[OP_A] = cls_a;
    assign cls_v[OP_B] = cls_b;
    assign cls_v[OP_C] = cls_c;

    for (genvar op = 0; op < NUM_OPS; op++) begin : g_dec
        fma_nan_cls_decode u_dec (
            .cls       (cls_v[op]),
            .is_quiet  (quiet_v[op]),
            .is_signal (signal_v[op])
        );
    end

    // slot NUM_RULES holds the fallback used by unassigned policy numbers
    for (genvar r = 0; r < RULE_SLOTS; r++) begin : g_rule
        fma_nan_rule #(.RULE(r)) u_rule (
            .quiet_v        (quiet_v),
            .signal_v       (signal_v),
            .infzero        (infzero),
            .qbit_inverted  (qbit_inverted),
            .first_nan_mode (first_nan_mode),
            .res            (rule_res[r])
        );
    end

    assign nan_pad = {1'b0, quiet_v | signal_v};

    always_comb begin
        sel_d = rule_res[NUM_RULES];
        for (int k = 0; k < NUM_RULES; k++) begin
            if (int'(policy) == k) sel_d = rule_res[k];
        end

        AST_SNAN_RAISES: assert (!(|signal_v) || sel_d.invalid); // R9
        AST_RAISE_HAS_CAUSE: assert (!sel_d.invalid || (|signal_v) || infzero); // R9
        AST_POLICY3_DEFAULT: assert (int'(policy) != 3 || sel_d.choice == PICK_DEF); // R6
        AST_FALLBACK_NO_DEFAULT: assert (int'(policy) < NUM_RULES || sel_d.choice != PICK_DEF); // R10
        AST_PICKED_IS_NAN: assert (infzero || sel_d.choice == PICK_DEF || !(|nan_pad)
                                   || nan_pad[sel_d.choice]); // R5
    end

    assign pick    = sel_d.choice;
    assign invalid = sel_d.invalid;

endmodule

// File: tb/fma_nan_select_test.sv
module fma_nan_select_test;

    logic       clk = 1'b0;
    logic [1:0] cls_a = 2'd0;
    logic [1:0] cls_b = 2'd0;
    logic [1:0] cls_c = 2'd0;
    logic       infzero = 1'b0;
    logic       qbit_inverted = 1'b0;
    logic       first_nan_mode = 1'b0;
    logic [2:0] policy = 3'd0;
    logic [1:0] pick;
    logic       invalid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    fma_nan_select uut (
        .cls_a          (cls_a),
        .cls_b          (cls_b),
        .cls_c          (cls_c),
        .infzero        (infzero),
        .qbit_inverted  (qbit_inverted),
        .first_nan_mode (first_nan_mode),
        .policy         (policy),
        .pick           (pick),
        .invalid        (invalid)
    );

    // reference model written from the requirement list; returns {invalid, pick}
    function automatic logic [2:0] model(input logic [1:0] ca, cb, cc,
                                         input logic iz, inv, fst,
                                         input logic [2:0] pol);
        bit qa = (ca == 2'd1), qb = (cb == 2'd1), qc = (cc == 2'd1);
        bit sa = (ca == 2'd2), sb = (cb == 2'd2), sc = (cc == 2'd2);
        bit na = qa | sa, nb = qb | sb, nc = qc | sc;
        logic [1:0] p;
        bit r = 1'b0;
        case (pol)
            3'd0: if (iz && qc) begin p = 2'd3; r = 1; end
                  else p = sc ? 2'd2 : sa ? 2'd0 : sb ? 2'd1 : qc ? 2'd2 : qa ? 2'd0 : 2'd1;
            3'd1: if (inv) begin
                      if (iz) begin p = 2'd3; r = 1; end
                      else p = sa ? 2'd0 : sb ? 2'd1 : sc ? 2'd2 : qa ? 2'd0 : qb ? 2'd1 : 2'd2;
                  end else begin
                      if (iz) begin p = 2'd2; r = 1; end
                      else p = sc ? 2'd2 : sa ? 2'd0 : sb ? 2'd1 : qc ? 2'd2 : qa ? 2'd0 : 2'd1;
                  end
            3'd2: if (iz) begin p = 2'd2; r = 1; end
                  else p = na ? 2'd0 : nc ? 2'd2 : 2'd1;
            3'd3: begin p = 2'd3; r = iz; end
            3'd4: if (iz) begin p = 2'd2; r = 1; end
                  else if (fst) p = na ? 2'd0 : nb ? 2'd1 : 2'd2;
                  else p = nc ? 2'd2 : nb ? 2'd1 : 2'd0;
            default: p = na ? 2'd0 : nb ? 2'd1 : 2'd2;
        endcase
        r = r | sa | sb | sc;
        return {r, p};
    endfunction

    function automatic string tag_for(input logic [2:0] pol, input logic inv, fst);
        case (pol)
            3'd0: return "R2";
            3'd1: return inv ? "R3" : "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return fst ? "R7" : "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] ca, cb, cc, input logic iz, inv, fst,
                         input logic [2:0] pol);
        @(posedge clk);
        cls_a = ca; cls_b = cb; cls_c = cc;
        infzero = iz; qbit_inverted = inv; first_nan_mode = fst; policy = pol;
        @(negedge clk);
    endtask

    task automatic run_vector(input logic [1:0] ca, cb, cc, input logic iz, inv, fst,
                              input logic [2:0] pol, input string tag_override);
        logic [2:0] e;
        string t;
        apply(ca, cb, cc, iz, inv, fst, pol);
        e = model(ca, cb, cc, iz, inv, fst, pol);
        t = (tag_override != "") ? tag_override : tag_for(pol, inv, fst);
        check(t, "pick", int'(pick), int'(e[1:0]));
        check((ca == 2'd2 || cb == 2'd2 || cc == 2'd2) ? "R9" : t, "invalid",
              int'(invalid), int'(e[2]));
    endtask

    // idle: all operands ordinary numbers, output must follow in the same cycle (R11)
    task automatic t_idle;
        apply(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R11", "idle pick", int'(pick), 1);
        check("R11", "idle invalid", int'(invalid), 0);
        apply(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3);
        check("R11", "policy switch pick", int'(pick), 3);
    endtask

    task automatic t_sweep_policy(input logic [2:0] pol);
        for (int ca = 0; ca < 3; ca++)
            for (int cb = 0; cb < 3; cb++)
                for (int cc = 0; cc < 3; cc++)
                    for (int m = 0; m < 8; m++)
                        run_vector(2'(ca), 2'(cb), 2'(cc), m[0], m[1], m[2], pol, "");
    endtask

    // reserved class code 3 must behave like an ordinary number (R1)
    task automatic t_reserved_code;
        apply(2'd3, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 3'd4);
        check("R1", "reserved a,b ignored pick", int'(pick), 2);
        check("R1", "reserved a,b no invalid", int'(invalid), 0);
        apply(2'd3, 2'd2, 2'd3, 1'b0, 1'b0, 1'b0, 3'd2);
        check("R1", "reserved with snan b pick", int'(pick), 1);
        check("R1", "reserved with snan b invalid", int'(invalid), 1);
        apply(2'd3, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 3'd0);
        check("R1", "all reserved pick", int'(pick), 1);
    endtask

    task automatic t_unused_policies;
        for (int pol = 5; pol < 8; pol++)
            for (int ca = 0; ca < 3; ca++)
                for (int cb = 0; cb < 3; cb++)
                    for (int cc = 0; cc < 3; cc++)
                        for (int iz = 0; iz < 2; iz++)
                            run_vector(2'(ca), 2'(cb), 2'(cc), 1'(iz), 1'b0, 1'b0,
                                       3'(pol), "R10");
    endtask

    initial begin
        t_idle();
        for (int p = 0; p < 5; p++) t_sweep_policy(3'(p));
        t_reserved_code();
        t_unused_policies();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule